// File: doc/BRIEF.md
# Isochronous Source Packet Unpacker

This block takes source packets from the head of a receive packet buffer and hands their payload to an application port. Each incoming quadlet carries start and end markers. Each packet also carries a time stamp and two status flags: a CRC-error mark and an unreliable mark. The block releases a packet to a valid/ready output stream under a set of mode inputs. Those modes cover:

- receive enable and synchronous clear;
- trailing byte trimming;
- time stamp gating against the running cycle time;
- forwarding the stamp as a leading quadlet;
- early release of CRC-damaged packets;
- silent discard of unreliable packets.

The buffer head is considered one packet at a time. A packet waiting for its time stamp therefore stalls every packet behind it. Payload quadlets pass straight through once a packet is released, so the block adds no storage beyond the captured packet context. Byte lane 0 (`out_data[7:0]`) is the first byte of a quadlet. The last quadlet of each packet is marked with a byte-enable that drops the padded lanes from the high end.

Top module: `iso_unpacker`

## Requirements
- R1: While reset is asserted, and afterwards until a packet arrives, `out_valid`, `in_ready` and `pkt_waiting` are all 0.
- R2: The final quadlet of a delivered packet has `out_last`=1 and `out_be` = 4'b1111 >> pad, where pad is `cfg_pad` captured at the packet's first quadlet. Byte lanes with a clear enable read as zero. Every other delivered quadlet has `out_be`=4'b1111 and `out_last`=0.
- R3: With stamp processing on, stamp forwarding off and no CRC bypass, a packet stays held until ((stamp − cycle_time) mod 2^TS_W) is zero or has its top bit set. While held, `out_valid` and `in_ready` stay 0. A stamp that lies in the past releases at once, including across counter wrap.
- R4: With stamp processing and stamp forwarding both on, the packet is released without waiting. Its stamp, zero-extended, comes out first as one extra quadlet with `out_be`=4'b1111 and `out_last`=0, and the payload follows.
- R5: A packet flagged with a CRC error is released at once when `cfg_crc_bypass`=1. With the bypass clear, it waits for its stamp like any other packet.
- R6: When `cfg_drop_unrel`=1, a packet flagged unreliable has all its quadlets accepted (`in_ready`=1) and none delivered. With the bit clear, or the flag clear, the packet is delivered.
- R7: `cfg_rx_en` is sampled only when a packet's first quadlet is at the head. While it is 0 there, that quadlet is not accepted. Clearing it after a packet has started does not stop that packet from completing.
- R8: `pkt_waiting` is 1 in two cases: a first quadlet is at the head and no packet is in progress, or a captured packet is held before release. It is 0 during delivery and when the head is empty.
- R9: With stamp processing off, a packet is released at once and no stamp quadlet is emitted, whatever the forwarding bit says.
- R10: `cfg_clear` returns the block to idle on the next clock edge, ending any delivery (`out_valid`=0). While idle, any quadlet without a start marker is accepted and discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_clear | input | 1 | Synchronous clear back to idle |
| cfg_rx_en | input | 1 | Receive enable, sampled at packet start |
| cfg_pad | input | PAD_W | Bytes trimmed from each packet's last quadlet |
| cfg_stamp_en | input | 1 | Stamp processing on |
| cfg_stamp_out | input | 1 | Forward stamp as leading quadlet instead of gating |
| cfg_crc_bypass | input | 1 | Release CRC-error packets immediately |
| cfg_drop_unrel | input | 1 | Discard packets marked unreliable |
| cycle_time | input | TS_W | Current cycle time counter |
| in_valid | input | 1 | Buffer head quadlet valid |
| in_ready | output | 1 | Buffer head quadlet accepted |
| in_data | input | QW | Buffer head quadlet |
| in_sop | input | 1 | First quadlet of a packet |
| in_eop | input | 1 | Last quadlet of a packet |
| in_stamp | input | TS_W | Packet time stamp, valid with the first quadlet |
| in_crc_err | input | 1 | Packet CRC error flag, valid with the first quadlet |
| in_unrel | input | 1 | Packet unreliable flag, valid with the first quadlet |
| out_valid | output | 1 | Application quadlet valid |
| out_ready | input | 1 | Application accepts quadlet |
| out_data | output | QW | Application quadlet, trimmed lanes zero |
| out_last | output | 1 | Final quadlet of packet |
| out_be | output | QW/8 | Byte-enable of the quadlet |
| pkt_waiting | output | 1 | A packet sits in the buffer awaiting delivery |

## Verification
The assertions assume that the buffer behaves as a proper valid/ready source: once `in_valid` is up and not accepted, it stays up and `in_data` does not change. They also assume that the per-packet stamp and flags are steady while a first quadlet waits. The bench only advances its input index after it has seen a handshake, and it holds every field of a packet constant for the whole packet. It drops `in_valid` only after the last quadlet has been taken, or while a clear is applied. Cycle time advances by one per clock. This keeps the wrap-safe comparison meaningful: stamps are never more than half the counter range ahead.

// File: rtl/iso_unpk_pkg.sv
package iso_unpk_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_HOLD,
    S_STAMP,
    S_XFER,
    S_DROP
  } unpk_state_e;
endpackage

// File: rtl/iso_unpk_gate.sv
// Wrap-safe release test: the stamp is due once it is not ahead of the clock.
module iso_unpk_gate #(
  parameter int TS_W = 16
) (
  input  logic [TS_W-1:0] stamp,
  input  logic [TS_W-1:0] now,
  output logic            due
);
  logic [TS_W-1:0] gap;

  always_comb begin
    gap = stamp - now;
    due = (gap == '0) || gap[TS_W-1];
  end
endmodule

// File: rtl/iso_unpk_trim.sv
// Byte-lane trimming of the final quadlet.
module iso_unpk_trim #(
  parameter int NB    = 4,
  parameter int PAD_W = 2
) (
  input  logic [NB*8-1:0]  data_in,
  input  logic             last,
  input  logic [PAD_W-1:0] pad,
  output logic [NB*8-1:0]  data_out,
  output logic [NB-1:0]    be
);
  for (genvar g = 0; g < NB; g++) begin : g_lane
    always_comb begin
      be[g] = !last || ((g + int'(pad)) < NB);
      data_out[g*8 +: 8] = be[g] ? data_in[g*8 +: 8] : 8'h00;
    end
  end
endmodule

// File: rtl/iso_unpk_seq.sv
// Packet sequencer: captures the head packet's context and steps it through
// hold, optional stamp quadlet, payload transfer or discard.
module iso_unpk_seq
  import iso_unpk_pkg::*;
#(
  parameter int TS_W  = 16,
  parameter int PAD_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_clear,
  input  logic             cfg_rx_en,
  input  logic [PAD_W-1:0] cfg_pad,
  input  logic             cfg_stamp_en,
  input  logic             cfg_stamp_out,
  input  logic             cfg_crc_bypass,
  input  logic             cfg_drop_unrel,
  input  logic             due,
  input  logic             in_valid,
  input  logic             in_sop,
  input  logic             in_eop,
  input  logic [TS_W-1:0]  in_stamp,
  input  logic             in_crc_err,
  input  logic             in_unrel,
  input  logic             out_ready,
  output logic [TS_W-1:0]  stamp_q,
  output logic [PAD_W-1:0] pad_q,
  output logic             in_ready,
  output logic             out_valid,
  output logic             sel_stamp,
  output logic             last_raw,
  output logic             pkt_waiting
);
  unpk_state_e st_q, st_d;
  logic        crc_q;
  logic        cap;
  logic        gated;
  logic        head;

  always_comb begin
    st_d        = st_q;
    cap         = 1'b0;
    in_ready    = 1'b0;
    out_valid   = 1'b0;
    sel_stamp   = 1'b0;
    last_raw    = 1'b0;
    head        = in_valid && in_sop;
    gated       = cfg_stamp_en && !cfg_stamp_out && !(crc_q && cfg_crc_bypass);
    pkt_waiting = (st_q == S_HOLD) || ((st_q == S_IDLE) && head);
    unique case (st_q)
      S_IDLE: begin
        if (in_valid && !in_sop) begin
          in_ready = 1'b1;
        end else if (head && cfg_rx_en) begin
          cap  = 1'b1;
          st_d = (cfg_drop_unrel && in_unrel) ? S_DROP : S_HOLD;
        end
      end
      S_HOLD: begin
        if (!gated || due) begin
          st_d = (cfg_stamp_en && cfg_stamp_out) ? S_STAMP : S_XFER;
        end
      end
      S_STAMP: begin
        out_valid = 1'b1;
        sel_stamp = 1'b1;
        if (out_ready) st_d = S_XFER;
      end
      S_XFER: begin
        out_valid = in_valid;
        in_ready  = out_ready;
        last_raw  = in_eop;
        if (in_valid && out_ready && in_eop) st_d = S_IDLE;
      end
      S_DROP: begin
        in_ready = 1'b1;
        if (in_valid && in_eop) st_d = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
    if (cfg_clear) st_d = S_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stamp_q <= '0;
      pad_q   <= '0;
      crc_q   <= 1'b0;
    end else if (cap) begin
      stamp_q <= in_stamp;
      pad_q   <= cfg_pad;
      crc_q   <= in_crc_err;
    end
  end

  // R3: a gated packet whose stamp is not yet due stays held
  a_r3_hold_until_due: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_HOLD && gated && !due && !cfg_clear) |=> (st_q == S_HOLD));

  // R6: nothing reaches the application while a packet is being discarded
  a_r6_drop_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_DROP) |-> !out_valid);

  // R7: a packet under delivery only ends through its last quadlet or a clear
  a_r7_finish: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_XFER && !cfg_clear) |=> (st_q == S_XFER || st_q == S_IDLE));

  // R10: clear lands in idle on the next edge
  a_r10_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clear |=> (st_q == S_IDLE && !out_valid));

  // Input assumption: an offered, unaccepted quadlet is held steady
  a_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> in_valid);
endmodule

// File: rtl/iso_unpacker.sv
module iso_unpacker
  import iso_unpk_pkg::*;
#(
  parameter int QW    = 32,
  parameter int TS_W  = 16,
  localparam int NB    = QW / 8,
  localparam int PAD_W = $clog2(NB)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_clear,
  input  logic             cfg_rx_en,
  input  logic [PAD_W-1:0] cfg_pad,
  input  logic             cfg_stamp_en,
  input  logic             cfg_stamp_out,
  input  logic             cfg_crc_bypass,
  input  logic             cfg_drop_unrel,
  input  logic [TS_W-1:0]  cycle_time,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [QW-1:0]    in_data,
  input  logic             in_sop,
  input  logic             in_eop,
  input  logic [TS_W-1:0]  in_stamp,
  input  logic             in_crc_err,
  input  logic             in_unrel,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [QW-1:0]    out_data,
  output logic             out_last,
  output logic [NB-1:0]    out_be,
  output logic             pkt_waiting
);
  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  logic [TS_W-1:0]  stamp_q;
  logic [PAD_W-1:0] pad_q;
  logic             due;
  logic             sel_stamp;
  logic             last_raw;
  logic [QW-1:0]    pre_data;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  iso_unpk_gate #(.TS_W(TS_W)) i_gate (
    .stamp (stamp_q),
    .now   (cycle_time),
    .due   (due)
  );

  iso_unpk_seq #(.TS_W(TS_W), .PAD_W(PAD_W)) i_seq (
    .clk            (clk),
    .rst_n          (rst_sync_n),
    .cfg_clear      (cfg_clear),
    .cfg_rx_en      (cfg_rx_en),
    .cfg_pad        (cfg_pad),
    .cfg_stamp_en   (cfg_stamp_en),
    .cfg_stamp_out  (cfg_stamp_out),
    .cfg_crc_bypass (cfg_crc_bypass),
    .cfg_drop_unrel (cfg_drop_unrel),
    .due            (due),
    .in_valid       (in_valid),
    .in_sop         (in_sop),
    .in_eop         (in_eop),
    .in_stamp       (in_stamp),
    .in_crc_err     (in_crc_err),
    .in_unrel       (in_unrel),
    .out_ready      (out_ready),
    .stamp_q        (stamp_q),
    .pad_q          (pad_q),
    .in_ready       (in_ready),
    .out_valid      (out_valid),
    .sel_stamp      (sel_stamp),
    .last_raw       (last_raw),
    .pkt_waiting    (pkt_waiting)
  );

  assign pre_data = sel_stamp ? QW'(stamp_q) : in_data;
  assign out_last = last_raw;

  iso_unpk_trim #(.NB(NB), .PAD_W(PAD_W)) i_trim (
    .data_in  (pre_data),
    .last     (last_raw),
    .pad      (pad_q),
    .data_out (out_data),
    .be       (out_be)
  );

  // R2: only a final quadlet may carry a partial byte-enable
  a_r2_full_mid: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && !out_last) |-> (&out_be));

  // R2: the first byte lane of a delivered quadlet is always enabled
  a_r2_lane0: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid |-> out_be[0]);

  // R1: no activity at the edges while reset is held
  a_r1_quiet_reset: assert property (@(posedge clk)
    !rst_sync_n |-> (!out_valid && !in_ready));
endmodule

// File: tb/test_iso_unpacker.sv
`timescale 1ns/1ps
module test_iso_unpacker;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_clear, cfg_rx_en, cfg_stamp_en, cfg_stamp_out;
  logic        cfg_crc_bypass, cfg_drop_unrel;
  logic [1:0]  cfg_pad;
  logic [15:0] cycle_time;
  logic        in_valid, in_ready, in_sop, in_eop, in_crc_err, in_unrel;
  logic [31:0] in_data;
  logic [15:0] in_stamp;
  logic        out_valid, out_ready, out_last, pkt_waiting;
  logic [31:0] out_data;
  logic [3:0]  out_be;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  iso_unpacker i_iso_unpacker (
    .clk(clk), .rst_n(rst_n), .cfg_clear(cfg_clear), .cfg_rx_en(cfg_rx_en),
    .cfg_pad(cfg_pad), .cfg_stamp_en(cfg_stamp_en), .cfg_stamp_out(cfg_stamp_out),
    .cfg_crc_bypass(cfg_crc_bypass), .cfg_drop_unrel(cfg_drop_unrel),
    .cycle_time(cycle_time), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop), .in_stamp(in_stamp),
    .in_crc_err(in_crc_err), .in_unrel(in_unrel), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .out_be(out_be), .pkt_waiting(pkt_waiting)
  );

  typedef struct packed {
    logic [1:0]  pad;
    logic        sen, coff, snow, drop, crc, unrel, bp, midoff;
    logic [2:0]  len;
    logic [15:0] ct0, stamp;
    logic [3:0]  cnt;
  } vec_t;

  // pad sen coff snow drop crc unrel bp midoff len ct0 stamp expected-count
  localparam vec_t VEC [12] = '{
    '{2'd0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'd3,16'd100,  16'd108,  4'd3}, // R3 R2
    '{2'd1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'd2,16'h0200, 16'h0250, 4'd3}, // R4
    '{2'd2,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,3'd4,16'd10,   16'd3000, 4'd4}, // R5 bypass
    '{2'd3,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,3'd1,16'd50,   16'd56,   4'd1}, // R5 no bypass
    '{2'd0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,3'd4,16'd7,    16'd9,    4'd0}, // R6 drop
    '{2'd1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,3'd2,16'd20,   16'd900,  4'd2}, // R6 keep, R9
    '{2'd1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,3'd2,16'hFFFA, 16'h0004, 4'd2}, // R3 wrap
    '{2'd0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'd2,16'h1000, 16'h0FF0, 4'd2}, // R3 stale
    '{2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,3'd4,16'd0,    16'd0,    4'd4}, // R7 mid clear
    '{2'd2,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,3'd3,16'd5,    16'd77,   4'd4}, // R4 R2 backpressure
    '{2'd0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'd2,16'd5,    16'd400,  4'd2}, // R9
    '{2'd3,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,3'd2,16'd30,   16'd30,   4'd2}  // R6 flag clear
  };

  function automatic logic [31:0] pay(input int k);
    return 32'h04030201 + 32'(k) * 32'h10101010;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] got,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic idle_inputs();
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_data = '0;
    in_stamp = '0; in_crc_err = 1'b0; in_unrel = 1'b0;
  endtask

  task automatic run_vec(input int idx, input vec_t v);
    logic [36:0] got [8];
    logic [36:0] exp [8];
    int ng = 0, ne = 0, k = 0, first = -1, tail = 0, wmin;
    bit adv = 0;
    logic [15:0] gap;
    bit gated;
    cfg_pad = v.pad; cfg_stamp_en = v.sen; cfg_stamp_out = v.coff;
    cfg_crc_bypass = v.snow; cfg_drop_unrel = v.drop; cfg_rx_en = 1'b1;
    in_stamp = v.stamp; in_crc_err = v.crc; in_unrel = v.unrel;
    for (int n = 0; n < 400 && tail < 6; n++) begin
      @(negedge clk);
      if (adv) k++;
      adv = 0;
      if (v.midoff && k >= 1) cfg_rx_en = 1'b0;
      if (k < int'(v.len)) begin
        in_valid = 1'b1; in_data = pay(k);
        in_sop = (k == 0); in_eop = (k == int'(v.len) - 1);
      end else begin
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
      end
      cycle_time = v.ct0 + 16'(n);
      out_ready = v.bp ? ((n % 3) != 1) : 1'b1;
      #1;
      if (out_valid && first < 0) first = n;
      if (out_valid && out_ready) begin
        if (ng < 8) got[ng] = {out_last, out_be, out_data};
        ng++;
      end
      if (in_valid && in_ready) adv = 1;
      if (k >= int'(v.len)) tail++;
    end
    idle_inputs();
    cfg_rx_en = 1'b1;
    // expected stream from the requirements
    if (!(v.drop && v.unrel)) begin
      if (v.sen && v.coff) begin
        exp[ne] = {1'b0, 4'hF, 16'h0, v.stamp}; ne++;        // R4
      end
      for (int j = 0; j < int'(v.len); j++) begin
        logic [31:0] d = pay(j);
        logic [3:0]  be = 4'hF;
        if (j == int'(v.len) - 1) begin
          be = 4'hF >> v.pad;                                  // R2
          for (int b = 0; b < 4; b++) if (!be[b]) d[b*8 +: 8] = 8'h00;
        end
        exp[ne] = {j == int'(v.len) - 1, be, d}; ne++;
      end
    end
    chk(ne == int'(v.cnt), $sformatf("R2 R4 R6 table count v%0d", idx), 64'(ne), 64'(v.cnt));
    chk(ng == ne, $sformatf("R6 R7 R9 quadlet count v%0d", idx), 64'(ng), 64'(ne));
    chk(k == int'(v.len), $sformatf("R6 R7 input consumed v%0d", idx), 64'(k), 64'(v.len));
    for (int i = 0; i < ne && i < ng && i < 8; i++)
      chk(got[i] == exp[i], $sformatf("R2 R4 quadlet %0d v%0d", i, idx), 64'(got[i]), 64'(exp[i]));
    if (ne > 0) begin
      gated = v.sen && !v.coff && !(v.crc && v.snow);
      gap = v.stamp - v.ct0;
      wmin = (gated && !gap[15]) ? int'(gap) : 0;
      chk(first >= wmin && first <= wmin + 3,
          $sformatf("R3 R5 release cycle v%0d", idx), 64'(first), 64'(wmin));
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog got=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    rst_n = 1'b0;
    cfg_clear = 1'b0; cfg_rx_en = 1'b1; cfg_pad = '0; cfg_stamp_en = 1'b0;
    cfg_stamp_out = 1'b0; cfg_crc_bypass = 1'b0; cfg_drop_unrel = 1'b1;
    cycle_time = '0; out_ready = 1'b1;
    idle_inputs();
    repeat (3) @(negedge clk);
    #1;
    chk(!out_valid && !in_ready && !pkt_waiting, "R1 in reset",
        {out_valid, in_ready, pkt_waiting}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(!out_valid && !in_ready && !pkt_waiting, "R1 after reset",
        {out_valid, in_ready, pkt_waiting}, 0);

    foreach (VEC[i]) run_vec(i, VEC[i]);

    // R7 R8: packet waits at the head while receive is disabled
    @(negedge clk);
    cfg_rx_en = 1'b0; cfg_stamp_en = 1'b0; cfg_pad = 2'd0;
    in_valid = 1'b1; in_sop = 1'b1; in_eop = 1'b1; in_data = pay(5);
    begin
      bit stalled = 1;
      for (int n = 0; n < 8; n++) begin
        @(negedge clk); #1;
        if (in_ready || out_valid) stalled = 0;
      end
      chk(stalled, "R7 disabled head not taken", {in_ready, out_valid}, 0);
    end
    chk(pkt_waiting == 1'b1, "R8 waiting at head", pkt_waiting, 1);
    cfg_rx_en = 1'b1;
    @(negedge clk); #1;
    chk(pkt_waiting && !out_valid, "R8 waiting while held", {pkt_waiting, out_valid}, 2'b10);
    @(negedge clk); #1;
    chk(out_valid && !pkt_waiting && out_data == pay(5) && out_last,
        "R7 R8 delivery after enable", {out_valid, pkt_waiting, out_last, out_data},
        {1'b1, 1'b0, 1'b1, pay(5)});
    @(negedge clk);
    idle_inputs();
    #1;
    chk(!pkt_waiting && !out_valid, "R8 empty head", {pkt_waiting, out_valid}, 0);

    // R10: clear during delivery, then orphan quadlets are discarded
    in_valid = 1'b1; in_sop = 1'b1; in_eop = 1'b0; in_data = pay(0);
    begin
      bit taken = 0;
      for (int n = 0; n < 10 && !taken; n++) begin
        @(negedge clk); #1;
        if (in_ready && out_valid) taken = 1;
      end
      chk(taken, "R10 first quadlet delivered", taken, 1);
    end
    @(negedge clk);
    idle_inputs();
    cfg_clear = 1'b1;
    @(negedge clk);
    cfg_clear = 1'b0;
    for (int j = 1; j < 4; j++) begin
      in_valid = 1'b1; in_sop = 1'b0; in_eop = (j == 3); in_data = pay(j);
      #1;
      chk(in_ready && !out_valid, $sformatf("R10 orphan %0d discarded", j),
          {in_ready, out_valid}, 2'b10);
      @(negedge clk);
    end
    idle_inputs();
    @(negedge clk); #1;
    chk(!out_valid && !pkt_waiting, "R10 idle after clear", {out_valid, pkt_waiting}, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule